// File: doc/BRIEF.md
# SPI Controller with Fault Flags

This block is a byte-wide serial peripheral interface controller that works either as the bus master, generating the serial clock, or as a slave clocked from outside. Software talks to it through a small four-address register port: a control word, a status word of sticky flags, a clock divider and a data address. Writing the data address fills a one-byte transmit holding buffer that is moved into the shift register when a transfer starts. Reading the data address returns a one-byte receive buffer. Bytes travel most significant bit first, and all four combinations of clock polarity and clock phase are available.

Four sticky flags record events: byte complete, write collision, receive overrun and mode fault. Each error flag has a side effect. A collision throws away the write. An overrun keeps the older received byte. A mode fault, raised when another master pulls the select line low while this block is master with multi-master checking on, clears the enable and master bits so that the block leaves the bus. A single interrupt output is high whenever a flag is set and interrupts are enabled.

Top module: `spi_fault_ctrl`

## Requirements
- R1: After reset the control word (address 0), status word (address 1) and divider (address 2) read 0, `irq` is low and `sck_out` and `mosi_out` are low.
- R2: The done flag (status bit 0) sets when each byte completes, in master and in slave mode. The byte received most significant bit first is then readable at address 3.
- R3: Control bit 4 (polarity) sets the idle level of `sck_out`: whenever no transfer is running, `sck_out` equals that bit. Master loopback transfers are correct in all four polarity/phase modes.
- R4: With control bit 5 (phase) at 0, the first data bit is on the data output before the first clock edge and input is sampled on leading edges. With phase 1, output changes on leading edges and input is sampled on trailing edges.
- R5: In master mode each half period of `sck_out` lasts divider+1 system clocks.
- R6: A write to address 3 while the transmit buffer is still occupied sets the collision flag (status bit 1), and the write is discarded.
- R7: In slave mode, a byte that completes while the receive buffer is unread sets the overrun flag (status bit 2). The new byte is dropped and the old byte stays readable.
- R8: With enable, master and multi-master (control bits 0, 1, 2) set, a low `nss_in` sets the fault flag (status bit 3) and clears control bits 0 and 1.
- R9: Flags stay set until a 1 is written to their bit at address 1. `irq` is high exactly when control bit 3 is set and at least one flag is set.
- R10: In slave mode, `nss_in` going high in the middle of a byte aborts it without setting the done flag, and the next byte starts from its first bit.
- R11: The transmit buffer is double-buffered. While a byte is shifting, one more byte is accepted (status bit 5 shows it pending) and is sent next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read at address 3 frees the receive buffer) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Combined interrupt |
| sck_out | output | 1 | Serial clock driven in master mode |
| mosi_out | output | 1 | Master data out |
| miso_in | input | 1 | Master data in |
| sck_in | input | 1 | Serial clock received in slave mode |
| mosi_in | input | 1 | Slave data in |
| miso_out | output | 1 | Slave data out |
| nss_in | input | 1 | Select input (slave select, or fault detection in master mode) |

## Verification
Master transfers loop the data output back to the data input and run in all four polarity/phase modes with different byte values, so a mistake in the edge that samples or the edge that shifts shows up as a wrong byte. A slave bit-banger drives each mode independently and checks the output bits one at a time, which separates a first bit driven before any edge from one driven on the leading edge. Three back-to-back writes separate an accepted double-buffered write from a collision. Two unread slave bytes and a byte cut short by the select line separate overrun, which keeps the old byte, from an abort, which leaves no done flag behind.

// File: rtl/spi_fault_ctrl.sv
module spi_fault_ctrl #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          sck_out,
  output logic          mosi_out,
  input  logic          miso_in,
  input  logic          sck_in,
  input  logic          mosi_in,
  output logic          miso_out,
  input  logic          nss_in
);
  localparam int EW = $clog2(2*DW) + 1;
  localparam logic [EW-1:0] LAST = EW'(2*DW-1);
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DIV = 2'd2, A_DATA = 2'd3;

  logic [5:0]      ctrl;
  logic [3:0]      flg, clr;
  logic [DW-1:0]   div, dcnt, txbuf, rxbuf, tx_sh, rx_sh, ld_byte, rx_byte;
  logic [EW-1:0]   ecnt;
  logic [SYNC-1:0] sck_q, mosi_q, nss_q;
  logic tx_full, rx_full, busy, sck_r, out_r, s_prev;
  logic en, mst, mm, ie, cpol, cpha, s_rel, nss_lo, fault, m_tick;
  logic lead, trail, in_bit, fin, abort, load, wr_data, rd_data, wcol_ev, ovr_ev;

  assign {cpha, cpol, ie, mm, mst, en} = ctrl;

  assign nss_lo  = !nss_q[SYNC-1];
  assign s_rel   = sck_q[SYNC-1] ^ cpol;
  assign fault   = en & mst & mm & nss_lo;
  assign m_tick  = busy & mst & (dcnt == div);
  assign lead    = busy & (mst ? (m_tick & !sck_r) : (s_rel & !s_prev));
  assign trail   = busy & (mst ? (m_tick & sck_r)  : (!s_rel & s_prev));
  assign in_bit  = mst ? miso_in : mosi_q[SYNC-1];
  assign abort   = busy & (!en | fault | (!mst & !nss_lo));
  assign fin     = trail & (ecnt == LAST) & !abort;
  assign load    = en & !busy & !fault & (mst ? tx_full : nss_lo);
  assign ld_byte = tx_full ? txbuf : '0;
  assign rx_byte = cpha ? {rx_sh[DW-2:0], in_bit} : rx_sh;

  assign wr_data = wr_en & (addr == A_DATA);
  assign rd_data = rd_en & (addr == A_DATA);
  assign wcol_ev = wr_data & tx_full;
  assign ovr_ev  = fin & !mst & rx_full & !rd_data;
  assign clr     = (wr_en && addr == A_STAT) ? wdata[3:0] : 4'd0;

  assign irq      = ie & (|flg);
  assign sck_out  = cpol ^ sck_r;
  assign mosi_out = mst & out_r;
  assign miso_out = !mst & out_r;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = DW'(ctrl);
      A_STAT:  rdata = DW'({rx_full, tx_full, busy, flg});
      A_DIV:   rdata = div;
      default: rdata = rxbuf;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; flg <= '0; div <= '0; dcnt <= '0;
      txbuf <= '0; rxbuf <= '0; tx_sh <= '0; rx_sh <= '0; ecnt <= '0;
      sck_q <= '0; mosi_q <= '0; nss_q <= '1;
      tx_full <= 1'b0; rx_full <= 1'b0; busy <= 1'b0;
      sck_r <= 1'b0; out_r <= 1'b0; s_prev <= 1'b0;
    end else begin
      sck_q  <= {sck_q[SYNC-2:0], sck_in};
      mosi_q <= {mosi_q[SYNC-2:0], mosi_in};
      nss_q  <= {nss_q[SYNC-2:0], nss_in};
      s_prev <= s_rel;

      if (wr_en && addr == A_CTRL) ctrl <= wdata[5:0];
      if (fault) ctrl[1:0] <= 2'b00;
      if (wr_en && addr == A_DIV) div <= wdata;
      flg <= (flg & ~clr) | {fault, ovr_ev, wcol_ev, fin};

      if (wr_data && !tx_full) begin
        txbuf   <= wdata;
        tx_full <= 1'b1;
      end else if (load && tx_full) begin
        tx_full <= 1'b0;
      end

      if (rd_data) rx_full <= 1'b0;
      if (fin && !ovr_ev) begin
        rxbuf   <= rx_byte;
        rx_full <= 1'b1;
      end

      if (abort) begin
        busy  <= 1'b0;
        ecnt  <= '0;
        sck_r <= 1'b0;
      end else if (load) begin
        busy  <= 1'b1;
        ecnt  <= '0;
        dcnt  <= '0;
        sck_r <= 1'b0;
        rx_sh <= '0;
        if (cpha) tx_sh <= ld_byte;
        else begin
          out_r <= ld_byte[DW-1];
          tx_sh <= ld_byte << 1;
        end
      end else if (busy) begin
        if (mst) begin
          dcnt <= m_tick ? '0 : dcnt + 1'b1;
          if (m_tick) sck_r <= !sck_r;
        end
        if (lead || trail) ecnt <= ecnt + 1'b1;
        if ((lead && cpha) || (trail && !cpha)) begin
          out_r <= tx_sh[DW-1];
          tx_sh <= tx_sh << 1;
        end
        if ((lead && !cpha) || (trail && cpha)) rx_sh <= {rx_sh[DW-2:0], in_bit};
        if (fin) begin
          busy <= 1'b0;
          ecnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/spi_fault_ctrl_chk.sv
module spi_fault_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    addr,
  input logic          irq,
  input logic          sck_out,
  input logic          busy,
  input logic          tx_full,
  input logic [5:0]    ctrl,
  input logic [3:0]    flg,
  input logic [DW-1:0] txbuf,
  input logic [DW-1:0] rxbuf
);
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck_out == ctrl[4]));

  a_r6_wcol_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && tx_full) |=> $stable(txbuf));

  a_r7_ovr_keep: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg[2]) |-> $stable(rxbuf));

  a_r8_fault_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg[3]) |-> (ctrl[1:0] == 2'b00));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flg != 4'd0 && !(wr_en && addr == 2'd1)) |=> ((flg & $past(flg)) == $past(flg)));

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flg != 4'd0));
endmodule

bind spi_fault_ctrl spi_fault_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .irq(irq),
  .sck_out(sck_out), .busy(busy), .tx_full(tx_full), .ctrl(ctrl),
  .flg(flg), .txbuf(txbuf), .rxbuf(rxbuf)
);

// File: tb/spi_fault_ctrl_tb_top.sv
module spi_fault_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic irq, sck_out, mosi_out, miso_out;
  logic sck_in = 1'b0, mosi_in = 1'b0, nss_in = 1'b1;
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_fault_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sck_out(sck_out),
    .mosi_out(mosi_out), .miso_in(mosi_out), .sck_in(sck_in),
    .mosi_in(mosi_in), .miso_out(miso_out), .nss_in(nss_in)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = (a == 2'd3);
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    exp_q.push_back(d);
    wr(2'd3, d);
  endtask

  task automatic collect(input string req);
    logic [7:0] s, r;
    s = 8'd0;
    while (!s[0]) rd(2'd1, s);
    wr(2'd1, 8'h01);
    rd(2'd3, r);
    check(req, r, exp_q.pop_front());
  endtask

  task automatic sbyte(input logic [7:0] m, input logic [7:0] exp_out,
                       input logic cph, input logic cpl, input int nbits, input string req);
    logic [7:0] got;
    got = 8'd0;
    for (int i = 0; i < nbits; i++) begin
      if (!cph) begin
        mosi_in = m[7-i];
        repeat (4) @(negedge clk);
        got[7-i] = miso_out;
        sck_in = ~cpl;
        repeat (4) @(negedge clk);
        sck_in = cpl;
      end else begin
        sck_in = ~cpl;
        mosi_in = m[7-i];
        repeat (4) @(negedge clk);
        got[7-i] = miso_out;
        sck_in = cpl;
        repeat (4) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
    if (nbits == 8) check(req, got, exp_out);
  endtask

  task automatic master_mode(input logic [1:0] md, input logic [7:0] d);
    wr(2'd2, 8'd1);
    wr(2'd0, {2'b00, md[1], md[0], 4'b0011});
    check("R3 idle level before", sck_out, md[0]);
    send(d);
    collect("R2/R3 master loopback");
    check("R3 idle level after", sck_out, md[0]);
  endtask

  task automatic slave_mode(input logic [1:0] md, input logic [7:0] txb, input logic [7:0] rxb);
    sck_in = md[0];
    wr(2'd0, {2'b00, md[1], md[0], 4'b0001});
    wr(2'd3, txb);
    nss_in = 1'b0;
    repeat (4) @(negedge clk);
    sbyte(rxb, txb, md[1], md[0], 8, "R4 slave output bits");
    nss_in = 1'b1;
    repeat (4) @(negedge clk);
    exp_q.push_back(rxb);
    collect("R2 slave receive");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int t0, t1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd1, v); check("R1 status", v, 0);
    rd(2'd2, v); check("R1 divider", v, 0);
    check("R1 irq", irq, 0);
    check("R1 sck", sck_out, 0);
    check("R1 mosi", mosi_out, 0);

    // R2 R3 R4: master loopback in every mode
    master_mode(2'd0, 8'hA5);
    master_mode(2'd1, 8'h3C);
    master_mode(2'd2, 8'h81);
    master_mode(2'd3, 8'h5E);

    // R5 divider
    wr(2'd2, 8'd2);
    wr(2'd0, 8'h03);
    send(8'h69);
    @(posedge sck_out); t0 = cyc;
    @(posedge sck_out); t1 = cyc;
    check("R5 period div2", t1 - t0, 6);
    collect("R5 data");
    wr(2'd2, 8'd0);
    send(8'h17);
    @(posedge sck_out); t0 = cyc;
    @(posedge sck_out); t1 = cyc;
    check("R5 period div0", t1 - t0, 2);
    collect("R5 data div0");

    // R6 R11 R9: collision, double buffer, sticky flags and irq
    wr(2'd2, 8'd3);
    wr(2'd0, 8'h0B);
    send(8'hC1);
    send(8'h2D);
    wr(2'd3, 8'hFF);
    rd(2'd1, v);
    check("R6 collision flag", v[1], 1);
    check("R11 pending byte", v[5], 1);
    check("R9 irq on flag", irq, 1);
    collect("R11 first byte");
    collect("R6/R11 second byte, dropped write absent");
    rd(2'd1, v); check("R9 collision sticky", v[1], 1);
    wr(2'd1, 8'h0F);
    rd(2'd1, v); check("R9 cleared", v[3:0], 0);
    check("R9 irq low after clear", irq, 0);
    wr(2'd0, 8'h03);
    wr(2'd3, 8'h44);
    repeat (120) @(negedge clk);
    check("R9 irq masked", irq, 0);
    rd(2'd1, v); check("R9 done set while masked", v[0], 1);
    rd(2'd3, v); check("R2 masked byte", v, 8'h44);
    wr(2'd1, 8'h0F);

    // R4 R2: slave in every mode
    slave_mode(2'd0, 8'hB4, 8'h1E);
    slave_mode(2'd1, 8'h4B, 8'hE1);
    slave_mode(2'd2, 8'h96, 8'h72);
    slave_mode(2'd3, 8'h0F, 8'hD8);

    // R7 overrun
    sck_in = 1'b0;
    wr(2'd0, 8'h01);
    nss_in = 1'b0;
    repeat (4) @(negedge clk);
    sbyte(8'h3C, 8'h00, 1'b0, 1'b0, 8, "R7 first byte out");
    sbyte(8'hC3, 8'h00, 1'b0, 1'b0, 8, "R7 second byte out");
    nss_in = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd1, v); check("R7 overrun flag", v[2], 1);
    rd(2'd3, v); check("R7 old byte kept", v, 8'h3C);
    wr(2'd1, 8'h0F);

    // R10 abort
    wr(2'd3, 8'h81);
    nss_in = 1'b0;
    repeat (4) @(negedge clk);
    sbyte(8'hFF, 8'h00, 1'b0, 1'b0, 3, "R10 partial");
    nss_in = 1'b1;
    repeat (6) @(negedge clk);
    rd(2'd1, v);
    check("R10 no done on abort", v[0], 0);
    check("R10 idle after abort", v[4], 0);
    wr(2'd3, 8'h5A);
    nss_in = 1'b0;
    repeat (4) @(negedge clk);
    sbyte(8'h77, 8'h5A, 1'b0, 1'b0, 8, "R10 restart output");
    nss_in = 1'b1;
    repeat (4) @(negedge clk);
    exp_q.push_back(8'h77);
    collect("R10 restart receive");

    // R8 mode fault
    wr(2'd0, 8'h0F);
    nss_in = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd1, v); check("R8 fault flag", v[3], 1);
    rd(2'd0, v); check("R8 enables cleared", v, 8'h0C);
    check("R8 irq", irq, 1);
    nss_in = 1'b1;
    wr(2'd1, 8'h0F);
    check("R9 irq after fault clear", irq, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule